// File: doc/BRIEF.md
# Cache Line Push and Flush Sequencer

This block controls a 4-way set-associative copyback data cache of 128 sets with 16-byte lines. It holds the tag, valid and dirty state and the line data. A command can push one line, or flush the whole cache by walking every line. A push names its target by directory position (set and way), not by a memory address. If the target line is valid and dirty, the controller sends it to memory through a request/acknowledge write-back port. The address in that request is rebuilt from the stored tag and the set number. After the push, the line either stays valid and becomes clean, or is invalidated, as a control bit selects.

A small control register holds a cache-enable bit and an invalidate-after-push bit. A write to it can also fire a one-shot clear of every valid bit. Normal cache traffic comes in on an access port that does lookups and line writes. With the cache disabled, that port never hits and never allocates, but the stored tags, state and data are left as they were. A flush visits way 0 sets 0 to 127, then way 1, and so on through way 3. Each line takes two cycles when no write-back is needed.

Top module: `cline_push_seq`

## Requirements
- R1: After reset, `busy`, `done`, `wb_req` and `acc_hit` are low, both control bits are 0, and every line is invalid.
- R2: A single push takes its set from operand bits 10:4 and its way from operand bits 1:0. Operand bits 3:2 and 31:11 have no effect.
- R3: A push of a valid dirty line raises `wb_req` once. `wb_addr` is {tag, set, 4'b0000} and `wb_data` is the line's 16 bytes. Both stay stable until `wb_ack`, and `done` comes only after the acknowledge.
- R4: After a push, the line is invalid if control bit 1 (invalidate-after-push) is 1. Otherwise it is still valid, still hits, and is clean, so a second push makes no write-back.
- R5: A push of an invalid or clean line makes no write-back request, and `done` is high in the second cycle after the cycle in which the command was accepted.
- R6: `cmd_flush`=1 ignores the operand and pushes all 512 lines. Lines are taken in the order way 0 sets 0..127, then way 1, way 2, way 3. Every valid dirty line is written back exactly once, and `done` pulses once at the end.
- R7: `busy` is high from the cycle after acceptance through the `done` cycle. While `busy` is high, commands, control writes and accesses are ignored.
- R8: A control write with bit 2 = 1 invalidates every line. In the same write, bits 0 and 1 are loaded as usual, so the same write can disable the cache.
- R9: With control bit 0 (enable) at 0, lookups miss and writes change nothing. Tags, state and data are kept, so re-enabling hits again with the old data.
- R10: The enable bit has no effect on pushes, flushes or the invalidate-all write.
- R11: An access answers on `acc_hit`/`acc_rdata` in the cycle after the request. `acc_rdata` holds the line's data before any write, and is 0 on a miss. A write hit replaces the data and marks the line dirty. A write miss allocates into way `acc_way` as valid and dirty. A read miss allocates nothing.
- R12: When the block is idle and inputs collide in one cycle, the priority is command, then control write, then access; the lower-priority inputs in that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_flush | input | 1 | 1 = flush whole cache, 0 = push one line |
| cmd_operand | input | 32 | Directory index for a single push |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Bit 0 enable, bit 1 invalidate-after-push, bit 2 invalidate-all |
| acc_req | input | 1 | Access request |
| acc_wr | input | 1 | 1 = line write, 0 = lookup |
| acc_addr | input | 32 | Access byte address |
| acc_way | input | 2 | Way to allocate on a write miss |
| acc_wdata | input | 128 | Line write data |
| acc_hit | output | 1 | Access hit, one cycle after request |
| acc_rdata | output | 128 | Line data before the access, 0 on miss |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | 32 | Write-back line address |
| wb_data | output | 128 | Write-back line data |
| wb_ack | input | 1 | Write-back acknowledge |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command completion pulse |

## Verification
The hardest case to reach from the ports is a control write, an access or a second command arriving in the middle of a long flush. If the block wrongly took that input, the damage would show up hundreds of cycles later as a missing or extra write-back. The stimulus therefore fires an invalidate-all write, a line write and a command together a few cycles into a flush. The bench then checks every later write-back against a model in which those inputs did nothing. Write-back acknowledges are held off for a random number of cycles, so the hold-until-acknowledge behaviour is exercised under different wait lengths.

// File: rtl/cline_pkg.sv
// Package: shared encodings for the cache line push and flush sequencer.
// Assumes control write data is 3 bits wide with the bit positions below.
package cline_pkg;
    localparam int CTL_W        = 3;
    localparam int CTL_EN_BIT   = 0;  // cache enable
    localparam int CTL_INVP_BIT = 1;  // invalidate line after push
    localparam int CTL_INVA_BIT = 2;  // one-shot invalidate of every line

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOOK,
        SQ_WB,
        SQ_UPD
    } seq_state_e;
endpackage

// File: rtl/cline_ctl_reg.sv
// Module: control register holding enable and invalidate-after-push.
// Assumes wr_en is already gated by the caller (idle, no command present).
// The invalidate-all bit is not stored; it becomes a one-cycle pulse.
module cline_ctl_reg
    import cline_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    output logic             en_q,
    output logic             invp_q,
    output logic             inval_all
);
    // Load the stored control bits on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            invp_q <= 1'b0;
        end else if (wr_en) begin
            en_q   <= wdata[CTL_EN_BIT];
            invp_q <= wdata[CTL_INVP_BIT];
        end
    end

    // Turn the invalidate-all bit into a pulse for the directory.
    always_comb inval_all = wr_en && wdata[CTL_INVA_BIT];
endmodule

// File: rtl/cline_dir.sv
// Module: tag/state/data directory of a set-associative copyback cache.
// Line index is {way, set}. Valid and dirty are flat flop vectors, so
// invalidate-all finishes in one cycle. The sequencer port reads one line
// combinationally and updates it on seq_upd. The lookup port compares all
// ways of one set in parallel and writes on lk_wr_en. The caller keeps the
// update sources mutually exclusive.
module cline_dir #(
    parameter int SETS       = 128,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 16,
    parameter int ADDR_W     = 32
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            inval_all,
    input  logic [$clog2(SETS*WAYS)-1:0]                    seq_idx,
    input  logic                                            seq_upd,
    input  logic                                            seq_drop,
    output logic                                            line_valid,
    output logic                                            line_dirty,
    output logic [ADDR_W-$clog2(SETS)-$clog2(LINE_BYTES)-1:0] line_tag,
    output logic [LINE_BYTES*8-1:0]                         line_data,
    input  logic [$clog2(SETS)-1:0]                         lk_set,
    input  logic [ADDR_W-$clog2(SETS)-$clog2(LINE_BYTES)-1:0] lk_tag,
    input  logic                                            lk_wr_en,
    input  logic [$clog2(WAYS)-1:0]                         lk_way,
    input  logic [LINE_BYTES*8-1:0]                         lk_wdata,
    output logic                                            lk_hit,
    output logic [LINE_BYTES*8-1:0]                         lk_hit_data
);
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LINES  = SETS * WAYS;
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int DATA_W = LINE_BYTES * 8;

    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [DATA_W-1:0] data_mem [LINES];
    logic [WAYS-1:0]   way_match;
    logic [WAY_W-1:0]  hit_way;
    logic [IDX_W-1:0]  wr_idx;

    // Sequencer read port: state and contents of the addressed line.
    always_comb begin
        line_valid = valid_q[seq_idx];
        line_dirty = dirty_q[seq_idx];
        line_tag   = tag_mem[seq_idx];
        line_data  = data_mem[seq_idx];
    end

    // One tag comparator per way of the looked-up set.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        localparam logic [WAY_W-1:0] WID = WAY_W'(w);
        assign way_match[w] = valid_q[{WID, lk_set}] && (tag_mem[{WID, lk_set}] == lk_tag);
    end

    // Encode the matching way, lowest index first.
    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_match[w]) hit_way = WAY_W'(w);
        end
        lk_hit      = |way_match;
        lk_hit_data = data_mem[{hit_way, lk_set}];
        wr_idx      = lk_hit ? {hit_way, lk_set} : {lk_way, lk_set};
    end

    // Valid/dirty state: reset, global clear, push update, access write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (inval_all) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (seq_upd) begin
                dirty_q[seq_idx] <= 1'b0;
                if (seq_drop) valid_q[seq_idx] <= 1'b0;
            end
            if (lk_wr_en) begin
                valid_q[wr_idx] <= 1'b1;
                dirty_q[wr_idx] <= 1'b1;
            end
        end
    end

    // Tag and data storage written only by access-port writes.
    always_ff @(posedge clk) begin
        if (lk_wr_en) begin
            tag_mem[wr_idx]  <= lk_tag;
            data_mem[wr_idx] <= lk_wdata;
        end
    end

    AST_INVAL_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inval_all) |-> (valid_q == '0)); // R8
    AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_q & ~valid_q) == '0); // R4
    AST_SINGLE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_match)); // R11
endmodule

// File: rtl/cline_seq.sv
// Module: push/flush sequencer. For each line it reads the state (LOOK).
// If the line is valid and dirty, it holds a write-back request until
// acknowledge (WB). It then cleans or invalidates the line (UPD). In flush
// mode the index counts from 0 to LINES-1, sets first within each way.
// Assumes the directory does not change while busy except through seq_upd.
module cline_seq
    import cline_pkg::*;
#(
    parameter int SETS       = 128,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 16,
    parameter int ADDR_W     = 32
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            cmd_fire,
    input  logic                                            cmd_flush,
    input  logic [$clog2(SETS*WAYS)-1:0]                    cmd_idx,
    input  logic                                            invp,
    input  logic                                            line_valid,
    input  logic                                            line_dirty,
    input  logic [ADDR_W-$clog2(SETS)-$clog2(LINE_BYTES)-1:0] line_tag,
    input  logic [LINE_BYTES*8-1:0]                         line_data,
    output logic [$clog2(SETS*WAYS)-1:0]                    seq_idx,
    output logic                                            seq_upd,
    output logic                                            seq_drop,
    output logic                                            wb_req,
    output logic [ADDR_W-1:0]                               wb_addr,
    output logic [LINE_BYTES*8-1:0]                         wb_data,
    input  logic                                            wb_ack,
    output logic                                            busy,
    output logic                                            done
);
    localparam int SET_W  = $clog2(SETS);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LINES  = SETS * WAYS;
    localparam int IDX_W  = $clog2(LINES);
    localparam int DATA_W = LINE_BYTES * 8;

    seq_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic              flush_q;
    logic [ADDR_W-1:0] wb_addr_q;
    logic [DATA_W-1:0] wb_data_q;
    logic              more;

    // Another line remains only in flush mode before the last index.
    always_comb more = flush_q && (idx_q != IDX_W'(LINES - 1));

    // Main sequencing: accept, look up, write back, update, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            idx_q     <= '0;
            flush_q   <= 1'b0;
            wb_addr_q <= '0;
            wb_data_q <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (cmd_fire) begin
                    idx_q   <= cmd_flush ? '0 : cmd_idx;
                    flush_q <= cmd_flush;
                    state_q <= SQ_LOOK;
                end
                SQ_LOOK: if (line_valid && line_dirty) begin
                    wb_addr_q <= {line_tag, idx_q[SET_W-1:0], {OFF_W{1'b0}}};
                    wb_data_q <= line_data;
                    state_q   <= SQ_WB;
                end else begin
                    state_q <= SQ_UPD;
                end
                SQ_WB: if (wb_ack) state_q <= SQ_UPD;
                SQ_UPD: if (more) begin
                    idx_q   <= idx_q + IDX_W'(1);
                    state_q <= SQ_LOOK;
                end else begin
                    state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Decoded outputs of the current sequencing state.
    always_comb begin
        seq_idx  = idx_q;
        seq_upd  = (state_q == SQ_UPD);
        seq_drop = invp;
        wb_req   = (state_q == SQ_WB);
        wb_addr  = wb_addr_q;
        wb_data  = wb_data_q;
        busy     = (state_q != SQ_IDLE);
        done     = (state_q == SQ_UPD) && !more;
    end

    AST_WB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |=> wb_req && $stable(wb_addr) && $stable(wb_data)); // R3
    AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> line_valid && line_dirty); // R3
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy); // R7
    AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done)); // R7
endmodule

// File: rtl/cline_push_seq.sv
// Module: top of the cache line push and flush sequencer. It decodes the
// push operand (set in bits 10:4, way in bits 1:0) and orders same-cycle
// inputs (command, then control write, then access) while idle. It
// registers access responses one cycle after the request. Assumes
// WAY_W <= OFF_W so the way field fits in the operand's low nibble.
module cline_push_seq
    import cline_pkg::*;
#(
    parameter int SETS       = 128,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 16,
    parameter int ADDR_W     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    input  logic                          cmd_flush,
    input  logic [ADDR_W-1:0]             cmd_operand,
    input  logic                          ctl_we,
    input  logic [CTL_W-1:0]              ctl_wdata,
    input  logic                          acc_req,
    input  logic                          acc_wr,
    input  logic [ADDR_W-1:0]             acc_addr,
    input  logic [$clog2(WAYS)-1:0]       acc_way,
    input  logic [LINE_BYTES*8-1:0]       acc_wdata,
    output logic                          acc_hit,
    output logic [LINE_BYTES*8-1:0]       acc_rdata,
    output logic                          wb_req,
    output logic [ADDR_W-1:0]             wb_addr,
    output logic [LINE_BYTES*8-1:0]       wb_data,
    input  logic                          wb_ack,
    output logic                          busy,
    output logic                          done
);
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS * WAYS);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int DATA_W = LINE_BYTES * 8;

    logic              cmd_fire, ctl_fire, acc_fire, lk_en;
    logic              ctl_en, ctl_invp, inval_all;
    logic [IDX_W-1:0]  cmd_idx, seq_idx;
    logic              seq_upd, seq_drop;
    logic              line_valid, line_dirty;
    logic [TAG_W-1:0]  line_tag;
    logic [DATA_W-1:0] line_data;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_hit_data;
    logic              unused_bits;

    // Idle-time arbitration: command over control write over access.
    always_comb begin
        cmd_fire = cmd_valid && !busy;
        ctl_fire = ctl_we && !busy && !cmd_valid;
        acc_fire = acc_req && !busy && !cmd_valid && !ctl_we;
        lk_en    = acc_fire && ctl_en;
        cmd_idx  = {cmd_operand[WAY_W-1:0], cmd_operand[OFF_W +: SET_W]};
    end

    assign unused_bits = ^{cmd_operand[ADDR_W-1:OFF_W+SET_W], cmd_operand[OFF_W-1:WAY_W],
                           acc_addr[OFF_W-1:0]};

    cline_ctl_reg u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctl_fire),
        .wdata     (ctl_wdata),
        .en_q      (ctl_en),
        .invp_q    (ctl_invp),
        .inval_all (inval_all)
    );

    cline_dir #(.SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)) u_dir (
        .clk         (clk),
        .rst_n       (rst_n),
        .inval_all   (inval_all),
        .seq_idx     (seq_idx),
        .seq_upd     (seq_upd),
        .seq_drop    (seq_drop),
        .line_valid  (line_valid),
        .line_dirty  (line_dirty),
        .line_tag    (line_tag),
        .line_data   (line_data),
        .lk_set      (acc_addr[OFF_W +: SET_W]),
        .lk_tag      (acc_addr[ADDR_W-1 -: TAG_W]),
        .lk_wr_en    (lk_en && acc_wr),
        .lk_way      (acc_way),
        .lk_wdata    (acc_wdata),
        .lk_hit      (lk_hit),
        .lk_hit_data (lk_hit_data)
    );

    cline_seq #(.SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_fire   (cmd_fire),
        .cmd_flush  (cmd_flush),
        .cmd_idx    (cmd_idx),
        .invp       (ctl_invp),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag),
        .line_data  (line_data),
        .seq_idx    (seq_idx),
        .seq_upd    (seq_upd),
        .seq_drop   (seq_drop),
        .wb_req     (wb_req),
        .wb_addr    (wb_addr),
        .wb_data    (wb_data),
        .wb_ack     (wb_ack),
        .busy       (busy),
        .done       (done)
    );

    // Register the access response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_hit   <= 1'b0;
            acc_rdata <= '0;
        end else begin
            acc_hit   <= lk_en && lk_hit;
            acc_rdata <= (lk_en && lk_hit) ? lk_hit_data : '0;
        end
    end

    AST_NO_HIT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit |-> $past(ctl_en)); // R9
    AST_CTL_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctl_en) && $stable(ctl_invp)); // R7
    AST_NO_ACCESS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit |-> !$past(busy)); // R7
endmodule

// File: tb/cline_push_seq_tb_top.sv
// Bench: directed corner cases plus seeded random traffic, checked
// against a reference model of the directory kept inside the bench.
module cline_push_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SETS  = 128;
    localparam int WAYS  = 4;
    localparam int LINES = SETS * WAYS;
    localparam int LIMIT = 5000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0, cmd_flush = 1'b0;
    logic [31:0]  cmd_operand = '0;
    logic         ctl_we = 1'b0;
    logic [2:0]   ctl_wdata = '0;
    logic         acc_req = 1'b0, acc_wr = 1'b0;
    logic [31:0]  acc_addr = '0;
    logic [1:0]   acc_way = '0;
    logic [127:0] acc_wdata = '0;
    logic         acc_hit;
    logic [127:0] acc_rdata;
    logic         wb_req;
    logic [31:0]  wb_addr;
    logic [127:0] wb_data;
    logic         wb_ack = 1'b0;
    logic         busy, done;

    int checks = 0;
    int errors = 0;

    bit           mvalid [LINES];
    bit           mdirty [LINES];
    logic [20:0]  mtag   [LINES];
    logic [127:0] mdata  [LINES];
    bit           men  = 0;
    bit           minvp = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cline_push_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_flush(cmd_flush), .cmd_operand(cmd_operand),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .acc_req(acc_req), .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_way(acc_way),
        .acc_wdata(acc_wdata), .acc_hit(acc_hit), .acc_rdata(acc_rdata),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data), .wb_ack(wb_ack),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic int lidx(int way, int set);
        return way * SETS + set;
    endfunction

    function automatic logic [31:0] mk_addr(int tg, int st);
        return (32'(tg) << 11) | (32'(st) << 4);
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic int find_way(logic [31:0] a);
        for (int w = 0; w < WAYS; w++) begin
            if (mvalid[lidx(w, int'(a[10:4]))] && mtag[lidx(w, int'(a[10:4]))] == a[31:11]) return w;
        end
        return -1;
    endfunction

    function automatic int next_dirty(int from, int to);
        for (int i = from; i <= to; i++) begin
            if (mvalid[i] && mdirty[i]) return i;
        end
        return -1;
    endfunction

    task automatic do_reset();
        for (int i = 0; i < LINES; i++) begin
            mvalid[i] = 0; mdirty[i] = 0; mtag[i] = '0; mdata[i] = '0;
        end
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        men = 0; minvp = 0;
    endtask

    task automatic ctl_do(input logic [2:0] w);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = w;
        @(negedge clk);
        ctl_we = 1'b0;
        men = w[0]; minvp = w[1];
        if (w[2]) for (int i = 0; i < LINES; i++) begin mvalid[i] = 0; mdirty[i] = 0; end
    endtask

    // Access: R11 timing and data, R9 when disabled.
    task automatic acc_do(input bit wr, input logic [31:0] a, input int way,
                          input logic [127:0] d, input string rq);
        int w;
        bit eh;
        logic [127:0] ed;
        w = men ? find_way(a) : -1;
        eh = (w >= 0);
        ed = eh ? mdata[lidx(w, int'(a[10:4]))] : '0;
        @(negedge clk);
        acc_req = 1'b1; acc_wr = wr; acc_addr = a; acc_way = 2'(way); acc_wdata = d;
        @(negedge clk);
        acc_req = 1'b0; acc_wr = 1'b0;
        chk(acc_hit === eh, rq, "acc_hit", 128'(acc_hit), 128'(eh));
        chk(acc_rdata === ed, rq, "acc_rdata", acc_rdata, ed);
        if (men && wr) begin
            if (eh) begin
                mdata[lidx(w, int'(a[10:4]))] = d;
                mdirty[lidx(w, int'(a[10:4]))] = 1;
            end else begin
                mvalid[lidx(way, int'(a[10:4]))] = 1;
                mdirty[lidx(way, int'(a[10:4]))] = 1;
                mtag[lidx(way, int'(a[10:4]))]   = a[31:11];
                mdata[lidx(way, int'(a[10:4]))]  = d;
            end
        end
    endtask

    // Command run. mode 1: collide control write and access with the accept
    // cycle (R12). mode 2: poke command, control write and access mid-flush (R7).
    task automatic run_cmd(input bit flush, input logic [31:0] opnd, input int mode);
        int lo, hi, sp, k, nwb, wt, e;
        bit inwb, seen;
        logic [31:0] ea;
        if (flush) begin lo = 0; hi = LINES - 1; end
        else begin lo = lidx(int'(opnd[1:0]), int'(opnd[10:4])); hi = lo; end
        sp = lo; nwb = 0; wt = 0; inwb = 0; seen = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_flush = flush; cmd_operand = opnd;
        if (mode == 1) begin
            ctl_we = 1'b1; ctl_wdata = 3'b110;
            acc_req = 1'b1; acc_wr = 1'b1; acc_addr = mk_addr(9, 3); acc_way = 2'd0; acc_wdata = rnd128();
        end
        @(negedge clk);
        cmd_valid = 1'b0; cmd_flush = 1'b0; ctl_we = 1'b0; acc_req = 1'b0; acc_wr = 1'b0;
        k = 1;
        chk(busy === 1'b1, "R7", "busy after accept", 128'(busy), 128'(1));
        while (!seen && k < LIMIT) begin
            if (mode == 2 && k == 3) begin
                cmd_valid = 1'b1; cmd_flush = 1'b0; cmd_operand = '0;
                ctl_we = 1'b1; ctl_wdata = 3'b110;
                acc_req = 1'b1; acc_wr = 1'b1; acc_addr = mk_addr(9, 3); acc_way = 2'd0; acc_wdata = rnd128();
            end
            if (mode == 2 && k == 4) begin
                cmd_valid = 1'b0; ctl_we = 1'b0; acc_req = 1'b0; acc_wr = 1'b0;
            end
            if (wb_ack) begin
                wb_ack = 1'b0;
            end else if (wb_req) begin
                if (!inwb) begin
                    e = next_dirty(sp, hi);
                    if (e < 0) begin
                        chk(0, "R6", "unexpected write-back", 128'(wb_addr), 128'(0));
                        sp = hi + 1;
                    end else begin
                        ea = {mtag[e], 7'(e % SETS), 4'b0000};
                        chk(wb_addr === ea, flush ? "R6" : "R3", "wb_addr", 128'(wb_addr), 128'(ea));
                        chk(wb_data === mdata[e], "R3", "wb_data", wb_data, mdata[e]);
                        sp = e + 1;
                    end
                    nwb++; inwb = 1; wt = $urandom % 4;
                end
                if (wt == 0) begin
                    wb_ack = 1'b1; inwb = 0;
                end else begin
                    wt--;
                    chk(done === 1'b0, "R3", "done before ack", 128'(done), 128'(0));
                end
            end
            if (done === 1'b1) seen = 1;
            else begin @(negedge clk); k++; end
        end
        chk(seen, "R7", "done seen", 128'(seen), 128'(1));
        chk(next_dirty(sp, hi) < 0, flush ? "R6" : "R3", "missing write-back",
            128'(next_dirty(sp, hi)), 128'(-1));
        if (!flush && nwb == 0)
            chk(k == 2, "R5", "clean push latency", 128'(k), 128'(2));
        for (int i = lo; i <= hi; i++) begin
            if (minvp) mvalid[i] = 0;
            mdirty[i] = 0;
        end
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, flush ? "R6" : "R7", "idle after done",
            128'({busy, done}), 128'(0));
    endtask

    function automatic logic [31:0] mk_op(int way, int set);
        return (32'(set) << 4) | 32'(way);
    endfunction

    logic [127:0] d_old;

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        @(negedge clk);
        // R1: reset state
        chk(busy === 0 && done === 0, "R1", "busy/done after reset", 128'({busy, done}), 0);
        chk(wb_req === 0 && acc_hit === 0, "R1", "wb_req/acc_hit after reset", 128'({wb_req, acc_hit}), 0);
        acc_do(1'b1, mk_addr(1, 1), 0, rnd128(), "R1");   // enable 0 after reset: no alloc
        ctl_do(3'b001);
        acc_do(1'b0, mk_addr(1, 1), 0, '0, "R1");
        acc_do(1'b0, mk_addr(0, 0), 0, '0, "R1");

        // R11: allocate, hit, write hit returns old data, read miss no alloc
        acc_do(1'b1, mk_addr(2, 5), 1, rnd128(), "R11");
        acc_do(1'b0, mk_addr(2, 5), 0, '0, "R11");
        acc_do(1'b1, mk_addr(2, 5), 3, rnd128(), "R11");
        acc_do(1'b0, mk_addr(7, 5), 0, '0, "R11");
        acc_do(1'b0, mk_addr(7, 5), 0, '0, "R11");

        // R2/R3: push with junk in operand bits 3:2 and 31:11
        run_cmd(1'b0, 32'hFFFF_F800 | mk_op(1, 5) | 32'h0000_000C, 0);
        acc_do(1'b0, mk_addr(2, 5), 0, '0, "R4");      // still valid
        run_cmd(1'b0, mk_op(1, 5), 0);                  // R4: clean, no write-back
        run_cmd(1'b0, mk_op(3, 100), 0);                // R5: invalid line

        // R4: invalidate-after-push
        ctl_do(3'b011);
        acc_do(1'b1, mk_addr(2, 5), 0, rnd128(), "R11");
        run_cmd(1'b0, mk_op(1, 5), 0);
        acc_do(1'b0, mk_addr(2, 5), 0, '0, "R4");

        // R9: disable keeps contents
        ctl_do(3'b001);
        acc_do(1'b1, mk_addr(3, 9), 2, rnd128(), "R11");
        ctl_do(3'b000);
        acc_do(1'b0, mk_addr(3, 9), 0, '0, "R9");
        acc_do(1'b1, mk_addr(3, 9), 0, rnd128(), "R9");
        acc_do(1'b1, mk_addr(4, 9), 0, rnd128(), "R9");
        ctl_do(3'b001);
        acc_do(1'b0, mk_addr(3, 9), 0, '0, "R9");
        acc_do(1'b0, mk_addr(4, 9), 0, '0, "R9");

        // R10: push and invalidate-all work while disabled
        ctl_do(3'b000);
        run_cmd(1'b0, mk_op(2, 9), 0);
        ctl_do(3'b001);
        acc_do(1'b0, mk_addr(3, 9), 0, '0, "R10");
        acc_do(1'b1, mk_addr(3, 9), 0, rnd128(), "R10");
        ctl_do(3'b100);                                 // R8: clear all and disable
        acc_do(1'b1, mk_addr(5, 9), 1, rnd128(), "R8");
        ctl_do(3'b001);
        acc_do(1'b0, mk_addr(3, 9), 0, '0, "R8");
        acc_do(1'b0, mk_addr(5, 9), 0, '0, "R8");

        // R12: command beats control write and access in the same cycle
        acc_do(1'b1, mk_addr(6, 20), 2, rnd128(), "R11");
        run_cmd(1'b0, mk_op(2, 20), 1);
        acc_do(1'b0, mk_addr(6, 20), 0, '0, "R12");
        acc_do(1'b0, mk_addr(9, 3), 0, '0, "R12");
        // R12: control write beats access
        acc_do(1'b1, mk_addr(6, 21), 1, rnd128(), "R11");
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = 3'b101;
        acc_req = 1'b1; acc_wr = 1'b1; acc_addr = mk_addr(9, 4); acc_way = 2'd1; acc_wdata = rnd128();
        @(negedge clk);
        ctl_we = 1'b0; acc_req = 1'b0; acc_wr = 1'b0;
        men = 1; minvp = 0;
        for (int i = 0; i < LINES; i++) begin mvalid[i] = 0; mdirty[i] = 0; end
        acc_do(1'b0, mk_addr(9, 4), 0, '0, "R12");
        acc_do(1'b0, mk_addr(6, 21), 0, '0, "R12");

        // Random traffic against the model
        for (int n = 0; n < 400; n++) begin
            int r;
            r = $urandom % 10;
            if (r < 4)
                acc_do(1'b1, mk_addr($urandom % 6, $urandom % 8), $urandom % 4, rnd128(), "R11");
            else if (r < 6 || r == 9)
                acc_do(1'b0, mk_addr($urandom % 6, $urandom % 8), 0, '0, "R11");
            else if (r < 8)
                run_cmd(1'b0, ($urandom & 32'hFFFF_F80C) | mk_op($urandom % 4, $urandom % 8), 0);
            else
                ctl_do({3'(($urandom % 8) == 0), 1'($urandom % 2), 1'(($urandom % 4) != 0)});
        end

        // R6 and R7: flush with inputs poked mid-walk
        ctl_do(3'b001);
        for (int n = 0; n < 24; n++)
            acc_do(1'b1, mk_addr($urandom % 6, $urandom % 128), $urandom % 4, rnd128(), "R11");
        run_cmd(1'b1, 32'hDEAD_BEEF, 2);
        acc_do(1'b0, mk_addr(9, 3), 0, '0, "R7");
        run_cmd(1'b1, '0, 0);                           // all clean: no write-backs
        for (int n = 0; n < 24; n++)
            acc_do(1'b1, mk_addr($urandom % 6, $urandom % 128), $urandom % 4, rnd128(), "R11");
        ctl_do(3'b011);
        run_cmd(1'b1, '0, 0);
        for (int n = 0; n < 8; n++)
            acc_do(1'b0, mk_addr($urandom % 6, $urandom % 128), 0, '0, "R6");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule